// File: doc/BRIEF.md
# MSI Snooping Coherence Line Controller

This block keeps the coherence state of every line in one private write-back cache that shares a snooping bus with other caches. Each line is Invalid, Shared or Modified. The processor side issues reads, writes and evictions against a line index. Hits finish at once. A miss or an upgrade needs the bus. The controller requests the bus, drives one command after the grant, and keeps the bus until the sequence is finished: the fill arrives for a miss, or every other cache has acknowledged an invalidate.

The bus side watches commands from the other caches. A Shared copy drops to Invalid when another cache writes. A Modified copy is flushed onto the bus whenever another cache misses on it. After the flush it becomes Shared for a read miss and Invalid for a write miss or invalidate. Evicting a Modified line goes through a simple write-back request and acknowledge handshake. Evicting a Shared line is silent, because the next level already holds the current value.

Top module: `msi_line_ctrl`

## Requirements
- R1: Every line holds one of three codes on `line_states` (Invalid=0, Shared=1, Modified=2), with line i in bits [2i+1:2i]. Reset sets every line to Invalid and code 3 never appears.
- R2: A read to a Shared or Modified line raises `cpu_done` in the cycle after acceptance. It makes no bus request and leaves the state unchanged.
- R3: A read to an Invalid line raises `bus_req`. The cycle after the grant it drives command 1 (read miss) with the line on `bus_line`. When `fill_valid` arrives the line becomes Shared and `cpu_done` pulses.
- R4: A write to a Shared line drives command 3 (invalidate) after the grant. It completes only on `inv_ack_all`, and the line then becomes Modified.
- R5: A write to an Invalid line drives command 2 (write miss) and becomes Modified on `fill_valid`. A write to a Modified line completes in one cycle with no bus activity.
- R6: `bus_req` stays high from the request until the cycle in which the fill or acknowledge is taken. The command appears for exactly one cycle, the cycle after the grant, and never without a grant. A miss completes two cycles after the request is first seen.
- R7: A snooped read miss (command 1) on a Modified line pulses `snp_flush` with `snp_flush_line` in the following cycle, and the line becomes Shared.
- R8: A snooped write miss or invalidate (command 2 or 3) sends a Modified line to Invalid after a flush pulse. It sends a Shared line to Invalid with no flush. It does not change an Invalid line, and a snoop leaves every other line untouched.
- R9: Evicting a Modified line holds `wb_req` with `wb_line` until `wb_ack`, then the line is Invalid. Evicting a Shared or Invalid line gives Invalid and `cpu_done` the next cycle, with no bus or write-back activity.
- R10: `cpu_ready` is low in any cycle with `snp_valid`. If a pending upgrade loses its Shared line to a snoop before the grant, it issues a write miss instead of an invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_op | input | 2 | 0 read, 1 write, 2 evict |
| cpu_line | input | LW | Line index of request |
| cpu_ready | output | 1 | Request accepted this cycle if valid |
| cpu_done | output | 1 | Request finished (one-cycle pulse) |
| bus_req | output | 1 | Bus request, held across the sequence |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd | output | 2 | Issued command: 0 none, 1 read miss, 2 write miss, 3 invalidate |
| bus_line | output | LW | Line of issued command |
| fill_valid | input | 1 | Miss data returned |
| inv_ack_all | input | 1 | All other caches took the invalidate |
| snp_valid | input | 1 | Another cache's command on the bus |
| snp_cmd | input | 2 | Snooped command, same codes as bus_cmd |
| snp_line | input | LW | Snooped line |
| snp_flush | output | 1 | This cache supplies dirty data |
| snp_flush_line | output | LW | Line being supplied |
| wb_req | output | 1 | Write-back to next level requested |
| wb_line | output | LW | Line being written back |
| wb_ack | input | 1 | Write-back accepted |
| line_states | output | 2*NUM_LINES | Packed per-line state codes |

## Verification
Hits and silent evictions raise `cpu_done` one cycle after the accepting edge. A Modified eviction finishes one cycle after the acknowledge. A miss shows its command the cycle after the grant and finishes the cycle after the fill or acknowledge, so a miss takes exactly two cycles from the first `bus_req` sample. A snoop flush and its state change appear one cycle after the snoop. The bench drives every input at the falling edge and samples at the next falling edge, counting the cycles of each sequence against these figures. It sweeps every line, every starting state and every processor operation or snoop command.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_M = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_INVAL  = 2'd3
    } bus_cmd_t;

    typedef enum logic [1:0] {
        OP_RD    = 2'd0,
        OP_WR    = 2'd1,
        OP_EVICT = 2'd2,
        OP_RSVD  = 2'd3
    } cpu_op_t;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_ARB,
        FS_XFER,
        FS_WB
    } fsm_t;

    typedef struct packed {
        logic     hit;
        logic     need_wb;
        line_st_t hit_next;
    } cpu_dec_t;

    typedef struct packed {
        logic     flush;
        line_st_t nxt;
    } snp_res_t;

    // Reaction of one line to another cache's bus command.
    function automatic snp_res_t snoop_resolve(line_st_t st, bus_cmd_t cmd);
        snp_res_t r;
        r.flush = (st == ST_M) && (cmd != BC_NONE);
        r.nxt   = st;
        case (cmd)
            BC_RDMISS:          if (st == ST_M) r.nxt = ST_S;
            BC_WRMISS, BC_INVAL: r.nxt = ST_I;
            default:            r.nxt = st;
        endcase
        return r;
    endfunction

    // Command chosen at grant time from the live line state.
    function automatic bus_cmd_t miss_cmd(cpu_op_t op, line_st_t st);
        if (op == OP_WR)
            return (st == ST_S) ? BC_INVAL : BC_WRMISS;
        return BC_RDMISS;
    endfunction

endpackage

// File: rtl/msi_cpu_decode.sv
module msi_cpu_decode
    import msi_pkg::*;
(
    input  cpu_op_t  op,
    input  line_st_t st,
    output cpu_dec_t dec
);
    always_comb begin
        dec.hit      = 1'b0;
        dec.need_wb  = 1'b0;
        dec.hit_next = st;
        case (op)
            OP_WR: begin
                dec.hit      = (st == ST_M);
                dec.hit_next = ST_M;
            end
            OP_EVICT: begin
                dec.hit      = (st != ST_M);
                dec.need_wb  = (st == ST_M);
                dec.hit_next = ST_I;
            end
            default: begin
                dec.hit      = (st != ST_I);
                dec.hit_next = st;
            end
        endcase
    end
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int LW  = 2,
    parameter int IDX = 0
) (
    input  logic          snp_valid,
    input  bus_cmd_t      snp_cmd,
    input  logic [LW-1:0] snp_line,
    input  line_st_t      st,
    output logic          hit,
    output logic          flush,
    output line_st_t      nxt
);
    snp_res_t res;

    always_comb begin
        res   = snoop_resolve(st, snp_cmd);
        hit   = snp_valid && (snp_line == LW'(IDX)) && (snp_cmd != BC_NONE);
        flush = hit && res.flush;
        nxt   = res.nxt;
    end
endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
    import msi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int SW = 2 * NUM_LINES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_valid,
    input  logic [1:0]    cpu_op,
    input  logic [LW-1:0] cpu_line,
    output logic          cpu_ready,
    output logic          cpu_done,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [1:0]    bus_cmd,
    output logic [LW-1:0] bus_line,
    input  logic          fill_valid,
    input  logic          inv_ack_all,
    input  logic          snp_valid,
    input  logic [1:0]    snp_cmd,
    input  logic [LW-1:0] snp_line,
    output logic          snp_flush,
    output logic [LW-1:0] snp_flush_line,
    output logic          wb_req,
    output logic [LW-1:0] wb_line,
    input  logic          wb_ack,
    output logic [SW-1:0] line_states
);
    line_st_t           st_q [NUM_LINES];
    fsm_t               fsm_q;
    cpu_op_t            pend_op_q;
    logic [LW-1:0]      pend_line_q;
    logic               pend_inval_q;
    bus_cmd_t           cmd_q;
    logic               done_q;
    logic               flush_q;
    logic [LW-1:0]      flush_line_q;

    logic [NUM_LINES-1:0] snp_hit;
    logic [NUM_LINES-1:0] snp_fl;
    line_st_t             snp_nxt [NUM_LINES];
    cpu_dec_t             dec;
    bus_cmd_t             grant_cmd;
    logic                 xfer_end;

    // One snoop reaction unit per line.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_snoop
        msi_snoop_unit #(.LW(LW), .IDX(g)) u_snp (
            .snp_valid (snp_valid),
            .snp_cmd   (bus_cmd_t'(snp_cmd)),
            .snp_line  (snp_line),
            .st        (st_q[g]),
            .hit       (snp_hit[g]),
            .flush     (snp_fl[g]),
            .nxt       (snp_nxt[g])
        );
    end

    msi_cpu_decode u_dec (
        .op  (cpu_op_t'(cpu_op)),
        .st  (st_q[cpu_line]),
        .dec (dec)
    );

    always_comb begin
        grant_cmd = miss_cmd(pend_op_q, st_q[pend_line_q]);
        xfer_end  = pend_inval_q ? inv_ack_all : fill_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q        <= FS_IDLE;
            pend_op_q    <= OP_RD;
            pend_line_q  <= '0;
            pend_inval_q <= 1'b0;
            cmd_q        <= BC_NONE;
            done_q       <= 1'b0;
            flush_q      <= 1'b0;
            flush_line_q <= '0;
            for (int i = 0; i < NUM_LINES; i++) st_q[i] <= ST_I;
        end else begin
            done_q       <= 1'b0;
            cmd_q        <= BC_NONE;
            flush_q      <= |snp_fl;
            flush_line_q <= snp_line;
            for (int i = 0; i < NUM_LINES; i++)
                if (snp_hit[i]) st_q[i] <= snp_nxt[i];
            case (fsm_q)
                FS_IDLE: begin
                    if (cpu_valid && cpu_ready) begin
                        pend_op_q   <= cpu_op_t'(cpu_op);
                        pend_line_q <= cpu_line;
                        if (dec.hit) begin
                            st_q[cpu_line] <= dec.hit_next;
                            done_q         <= 1'b1;
                        end else if (dec.need_wb) begin
                            fsm_q <= FS_WB;
                        end else begin
                            fsm_q <= FS_ARB;
                        end
                    end
                end
                FS_ARB: begin
                    if (bus_gnt) begin
                        cmd_q        <= grant_cmd;
                        pend_inval_q <= (grant_cmd == BC_INVAL);
                        fsm_q        <= FS_XFER;
                    end
                end
                FS_XFER: begin
                    if (xfer_end) begin
                        st_q[pend_line_q] <= (pend_op_q == OP_WR) ? ST_M : ST_S;
                        done_q            <= 1'b1;
                        fsm_q             <= FS_IDLE;
                    end
                end
                FS_WB: begin
                    if (wb_ack) begin
                        st_q[pend_line_q] <= ST_I;
                        done_q            <= 1'b1;
                        fsm_q             <= FS_IDLE;
                    end
                end
                default: fsm_q <= FS_IDLE;
            endcase
        end
    end

    always_comb begin
        cpu_ready      = (fsm_q == FS_IDLE) && !snp_valid;
        cpu_done       = done_q;
        bus_req        = (fsm_q == FS_ARB) || (fsm_q == FS_XFER);
        bus_cmd        = cmd_q;
        bus_line       = pend_line_q;
        wb_req         = (fsm_q == FS_WB);
        wb_line        = pend_line_q;
        snp_flush      = flush_q;
        snp_flush_line = flush_line_q;
        for (int i = 0; i < NUM_LINES; i++) line_states[2*i +: 2] = st_q[i];
    end
endmodule

// File: rtl/msi_line_ctrl_chk.sv
module msi_line_ctrl_chk #(
    parameter int NUM_LINES = 4,
    localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int SW = 2 * NUM_LINES
) (
    input logic          clk,
    input logic          rst,
    input logic          cpu_ready,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic [1:0]    bus_cmd,
    input logic          snp_valid,
    input logic [1:0]    snp_cmd,
    input logic [LW-1:0] snp_line,
    input logic          snp_flush,
    input logic [SW-1:0] line_states
);
    logic [1:0] snp_cur;

    always_comb begin
        snp_cur = 2'd0;
        for (int i = 0; i < NUM_LINES; i++)
            if (snp_line == LW'(i)) snp_cur = line_states[2*i +: 2];
    end

    AST_CMD_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd != 2'd0) |-> $past(bus_gnt)); // R6
    AST_BUS_KEPT: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd != 2'd0) |-> bus_req); // R6
    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd != 2'd0) |=> (bus_cmd == 2'd0)); // R6
    AST_FLUSH_FROM_DIRTY: assert property (@(posedge clk) disable iff (rst)
        snp_flush |-> $past(snp_valid && (snp_cur == 2'd2) && (snp_cmd != 2'd0))); // R7
    AST_NO_ACCEPT_ON_SNOOP: assert property (@(posedge clk) disable iff (rst)
        snp_valid |-> !cpu_ready); // R10
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> !bus_req); // R6

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
            line_states[2*g +: 2] != 2'd3); // R1
        AST_DIRTY_VIA_BUS: assert property (@(posedge clk) disable iff (rst)
            (line_states[2*g +: 2] == 2'd2 && $past(line_states[2*g +: 2]) != 2'd2)
            |-> $past(bus_req)); // R4
    end
endmodule

bind msi_line_ctrl msi_line_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cpu_ready   (cpu_ready),
    .bus_req     (bus_req),
    .bus_gnt     (bus_gnt),
    .bus_cmd     (bus_cmd),
    .snp_valid   (snp_valid),
    .snp_cmd     (snp_cmd),
    .snp_line    (snp_line),
    .snp_flush   (snp_flush),
    .line_states (line_states)
);

// File: tb/tb_msi_line_ctrl.sv
`timescale 1ns/1ps
module tb_msi_line_ctrl;
    localparam int NL = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_valid = 1'b0;
    logic [1:0] cpu_op = 2'd0;
    logic [1:0] cpu_line = 2'd0;
    logic       cpu_ready, cpu_done, bus_req;
    logic       bus_gnt = 1'b0;
    logic [1:0] bus_cmd, bus_line;
    logic       fill_valid = 1'b0, inv_ack_all = 1'b0;
    logic       snp_valid = 1'b0;
    logic [1:0] snp_cmd = 2'd0, snp_line = 2'd0;
    logic       snp_flush;
    logic [1:0] snp_flush_line;
    logic       wb_req;
    logic [1:0] wb_line;
    logic       wb_ack = 1'b0;
    logic [7:0] line_states;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;
    logic [1:0] exp_st [NL];

    always #4 clk = ~clk;

    msi_line_ctrl #(.NUM_LINES(NL)) dut (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_line(cpu_line),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_line(bus_line),
        .fill_valid(fill_valid), .inv_ack_all(inv_ack_all),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_line(snp_line),
        .snp_flush(snp_flush), .snp_flush_line(snp_flush_line),
        .wb_req(wb_req), .wb_line(wb_line), .wb_ack(wb_ack),
        .line_states(line_states)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_vec();
        logic [7:0] v;
        for (int i = 0; i < NL; i++) v[2*i +: 2] = exp_st[i];
        return v;
    endfunction

    // Expected command: 0 none, 1 read miss, 2 write miss, 3 invalidate.
    function automatic logic [1:0] want_cmd_f(input logic [1:0] op, input logic [1:0] st);
        if (op == 2'd0) return (st == 2'd0) ? 2'd1 : 2'd0;
        if (op == 2'd1) return (st == 2'd0) ? 2'd2 : ((st == 2'd1) ? 2'd3 : 2'd0);
        return 2'd0;
    endfunction

    function automatic logic [1:0] next_st_f(input logic [1:0] op, input logic [1:0] st);
        if (op == 2'd0) return (st == 2'd0) ? 2'd1 : st;
        if (op == 2'd1) return 2'd2;
        return 2'd0;
    endfunction

    function automatic string tag_f(input logic [1:0] op, input logic [1:0] st);
        if (op == 2'd0) return (st == 2'd0) ? "R3" : "R2";
        if (op == 2'd1) return (st == 2'd1) ? "R4" : "R5";
        return "R9";
    endfunction

    task automatic access(input logic [1:0] op, input int line);
        logic [1:0] st0, want, got;
        bit   want_wb, got_wb, held;
        int   lat, want_lat;
        string tag;
        st0     = exp_st[line];
        want    = want_cmd_f(op, st0);
        want_wb = (op == 2'd2) && (st0 == 2'd2);
        want_lat = (want != 2'd0) ? 2 : (want_wb ? 1 : 0);
        tag     = tag_f(op, st0);
        got = 2'd0; got_wb = 0; held = 1; lat = 0;
        @(negedge clk);
        cpu_valid = 1'b1; cpu_op = op; cpu_line = line[1:0];
        @(negedge clk);
        cpu_valid = 1'b0;
        for (int n = 0; n < 40; n++) begin
            fill_valid = 1'b0; inv_ack_all = 1'b0; wb_ack = 1'b0;
            if (cpu_done) break;
            if (bus_cmd != 2'd0) begin
                got = bus_cmd;
                bus_gnt = 1'b0;
                if (!bus_req) held = 0;
                chk(bus_line == line[1:0], tag, "bus_line", bus_line, line);
                if (bus_cmd == 2'd3) inv_ack_all = 1'b1;
                else fill_valid = 1'b1;
            end else if (bus_req && got == 2'd0) begin
                bus_gnt = 1'b1;
            end
            if (wb_req) begin
                got_wb = 1;
                wb_ack = 1'b1;
                chk(wb_line == line[1:0], "R9", "wb_line", wb_line, line);
            end
            @(negedge clk);
            lat++;
        end
        exp_st[line] = next_st_f(op, st0);
        chk(got == want, tag, "bus command", got, want);
        chk(got_wb == want_wb, "R9", "write-back seen", got_wb, want_wb);
        chk(lat == want_lat, "R6", "cycles to done", lat, want_lat);
        chk(held, "R6", "bus held during command", held, 1);
        chk(line_states == exp_vec(), tag, "line states", line_states, exp_vec());
        chk(!bus_req && !wb_req, "R6", "released", {bus_req, wb_req}, 0);
    endtask

    task automatic snoop(input logic [1:0] cmd, input int line);
        logic [1:0] st0;
        bit   want_fl;
        string tag;
        st0     = exp_st[line];
        want_fl = (st0 == 2'd2);
        tag     = (cmd == 2'd1) ? "R7" : "R8";
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = cmd; snp_line = line[1:0];
        #1;
        chk(cpu_ready == 1'b0, "R10", "ready during snoop", cpu_ready, 0);
        @(negedge clk);
        snp_valid = 1'b0;
        if (cmd == 2'd1) exp_st[line] = (st0 == 2'd2) ? 2'd1 : st0;
        else exp_st[line] = 2'd0;
        chk(snp_flush == want_fl, tag, "flush", snp_flush, want_fl);
        if (want_fl)
            chk(snp_flush_line == line[1:0], tag, "flush line", snp_flush_line, line);
        chk(line_states == exp_vec(), tag, "states after snoop", line_states, exp_vec());
    endtask

    task automatic setup(input int line, input int s);
        access(2'd2, line);
        if (s == 1) access(2'd0, line);
        if (s == 2) access(2'd1, line);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < NL; i++) exp_st[i] = 2'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(line_states == 8'd0, "R1", "reset states", line_states, 0);
        chk(cpu_ready && !bus_req && !wb_req, "R1", "reset idle",
            {cpu_ready, bus_req, wb_req}, 4);

        // Every line, start state and processor operation.
        for (int line = 0; line < NL; line++)
            for (int s = 0; s < 3; s++)
                for (int op = 0; op < 3; op++) begin
                    setup(line, s);
                    access(op[1:0], line);
                end

        // Every start state and snooped command, with other lines held in mixed states.
        setup(0, 2); setup(1, 1); setup(2, 0); setup(3, 2);
        for (int line = 0; line < NL; line++)
            for (int s = 0; s < 3; s++)
                for (int c = 1; c < 4; c++) begin
                    setup(line, s);
                    snoop(c[1:0], line);
                end

        // Pending upgrade loses its Shared copy before the grant (R10).
        setup(1, 1);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_op = 2'd1; cpu_line = 2'd1;
        @(negedge clk);
        cpu_valid = 1'b0;
        chk(bus_req, "R10", "request raised", bus_req, 1);
        snp_valid = 1'b1; snp_cmd = 2'd3; snp_line = 2'd1;
        @(negedge clk);
        snp_valid = 1'b0;
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        chk(bus_cmd == 2'd2, "R10", "demoted command", bus_cmd, 2);
        fill_valid = 1'b1;
        @(negedge clk);
        fill_valid = 1'b0;
        exp_st[1] = 2'd2;
        chk(cpu_done, "R10", "done after fill", cpu_done, 1);
        chk(line_states == exp_vec(), "R10", "state after demoted write",
            line_states, exp_vec());

        finish_run();
    end
endmodule